// File: doc/BRIEF.md
# Dual-Direction Word Mailbox with Flag Handshake

This block joins two processors that each have only a plain asynchronous memory port. Each direction has its own one-word holding latch. Side A writes words that side B reads, and side B writes words that side A reads. All control runs on one synchronous clock. An access from either side takes two clocks: a setup clock and then a strobe clock. A write strobe opens the latch enable of that side's outgoing latch. A read strobe drops the active-low output enable of that side's incoming latch, so the word appears on the read bus.

Two one-clock flag pulses pace each direction. The receiver gets a "word ready" pulse once a word has been captured. The sender gets a "word taken" pulse once the receiver has read a held word. Both are rising-edge events. Each direction also exposes a full status bit and a sticky overrun bit. The overrun bit is raised when the sender writes again before the previous word has been taken.

Top module: `dual_mailbox`

## Requirements
- R1: After reset, both read buses are 0, both output enables are high (inactive), and all ready flags, taken flags, full bits and overrun bits are 0.
- R2: An access is a select held for at least two clocks. The first clock is setup and the second is strobe. A select lasting only one clock does nothing. Holding the select longer than two clocks gives exactly one strobe per access.
- R3: A write strobe (we=1) to an empty direction captures the write data into that direction's latch at the end of the strobe clock. The sender's full bit reads 1 from the next clock on.
- R4: The cycle after a word is captured, the receiver's ready flag is 1 for exactly one clock.
- R5: A side's output enable is low, and its read bus carries the incoming word, only during the strobe clock of a read (we=0). At all other times the output enable is high and the read bus is 0.
- R6: A read strobe on a full direction produces a one-clock taken flag at the sender in the following cycle. In that same cycle the full bit reads 0.
- R7: A write strobe to a full direction is dropped, and the held word stays unchanged. No ready flag is produced. The sender's overrun bit goes to 1 and stays 1 until reset.
- R8: A read strobe on an empty direction produces no taken flag and leaves the full bit at 0.
- R9: If a read strobe falls in the same clock as the write strobe into an empty latch, the reader sees the incoming word through the transparent latch. The word is not counted as taken: no taken flag is produced and the full bit stays 1.
- R10: The two directions work independently. Simultaneous writes from both sides, and simultaneous reads from both sides, each complete with their own flags and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Side A access select |
| a_we | input | 1 | Side A access is a write when 1 |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A read bus (word from B), 0 when released |
| a_oe_n | output | 1 | Output enable of the B-to-A latch, active low |
| a_ready | output | 1 | Pulse: a word from B is waiting for A |
| a_taken | output | 1 | Pulse: B has taken A's word |
| a_full | output | 1 | A-to-B latch holds an untaken word |
| a_ovr | output | 1 | Sticky: A wrote while A-to-B was full |
| b_sel | input | 1 | Side B access select |
| b_we | input | 1 | Side B access is a write when 1 |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B read bus (word from A), 0 when released |
| b_oe_n | output | 1 | Output enable of the A-to-B latch, active low |
| b_ready | output | 1 | Pulse: a word from A is waiting for B |
| b_taken | output | 1 | Pulse: A has taken B's word |
| b_full | output | 1 | B-to-A latch holds an untaken word |
| b_ovr | output | 1 | Sticky: B wrote while B-to-A was full |

## Verification
The hardest case to reach is the collision in R9: a read strobe on one side must land in exactly the clock where the other side's write strobe fills the same empty latch. The bench reaches it with a task that starts both accesses on the same falling edge, so both setup clocks and both strobe clocks line up. It then samples the reader's bus in the strobe clock and the full and taken bits in the clock after. Overrun is placed last, because the overrun bit stays set once raised and would mask later checks.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;

  // Access phase sequencing: one setup clock, one strobe clock, then wait for select release.
  function automatic phase_e phase_next(input phase_e cur, input logic sel);
    phase_e nx;
    case (cur)
      PH_IDLE:  nx = sel ? PH_SETUP : PH_IDLE;
      PH_SETUP: nx = sel ? PH_HOLD  : PH_IDLE;
      PH_HOLD:  nx = sel ? PH_HOLD  : PH_IDLE;
      default:  nx = PH_IDLE;
    endcase
    return nx;
  endfunction

  // Occupancy update: an accepted write only ever happens when empty.
  function automatic logic occ_next(input logic full, input logic accept, input logic take);
    return (full & ~take) | accept;
  endfunction

endpackage

// File: rtl/mbx_port_seq.sv
module mbx_port_seq
  import mbx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic we,
  output logic wr_stb,
  output logic rd_stb
);

  phase_e ph_q;
  logic   setup_w;
  logic   stb_w;

  assign setup_w = sel & (ph_q == PH_IDLE);
  assign stb_w   = sel & (ph_q == PH_SETUP);
  assign wr_stb  = stb_w & we;
  assign rd_stb  = stb_w & ~we;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= phase_next(ph_q, sel);
  end

  // R2: a strobe clock is always preceded by a setup clock
  p_strobe_after_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb | rd_stb) |-> $past(setup_w));

  // R2: never two strobe clocks back to back
  p_single_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb | rd_stb) |=> !(wr_stb | rd_stb));

endmodule

// File: rtl/mbx_lane.sv
module mbx_lane
  import mbx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wdata,
  input  logic         rd_stb,
  output logic [W-1:0] rdata,
  output logic         oe_n,
  output logic         full,
  output logic         ovr,
  output logic         ready_p,
  output logic         taken_p
);

  logic [W-1:0] hold_q;
  logic         full_q, ovr_q, rdy_q, tkn_q;
  logic         le_w;      // latch enable: accepted write
  logic         take_w;    // reader removes a held word
  logic         clash_w;   // write while occupied

  assign le_w    = wr_stb & ~full_q;
  assign take_w  = rd_stb & full_q;
  assign clash_w = wr_stb & full_q;

  assign oe_n  = ~rd_stb;
  assign rdata = rd_stb ? (le_w ? wdata : hold_q) : '0;

  assign full    = full_q;
  assign ovr     = ovr_q;
  assign ready_p = rdy_q;
  assign taken_p = tkn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      rdy_q  <= 1'b0;
      tkn_q  <= 1'b0;
    end else begin
      if (le_w) hold_q <= wdata;
      full_q <= occ_next(full_q, le_w, take_w);
      ovr_q  <= ovr_q | clash_w;
      rdy_q  <= le_w;
      tkn_q  <= take_w;
    end
  end

  // R3: occupancy only rises after a write strobe
  p_full_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_q) |-> $past(wr_stb));

  // R4: ready is a single-clock pulse
  p_ready_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> !rdy_q);

  // R6: a taken pulse means the word has left the latch
  p_taken_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tkn_q |-> (!full_q && $past(full_q)));

  // R7: a held word cannot be overwritten
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> $stable(hold_q));

  // R7: overrun is sticky
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);

endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
  import mbx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_sel,
  input  logic         a_we,
  input  logic [W-1:0] a_wdata,
  output logic [W-1:0] a_rdata,
  output logic         a_oe_n,
  output logic         a_ready,
  output logic         a_taken,
  output logic         a_full,
  output logic         a_ovr,
  input  logic         b_sel,
  input  logic         b_we,
  input  logic [W-1:0] b_wdata,
  output logic [W-1:0] b_rdata,
  output logic         b_oe_n,
  output logic         b_ready,
  output logic         b_taken,
  output logic         b_full,
  output logic         b_ovr
);

  localparam int NSIDE = 2;

  // index 0 = side A, 1 = side B; lane d carries words written by side d
  logic         sel_w   [NSIDE];
  logic         we_w    [NSIDE];
  logic [W-1:0] wd_w    [NSIDE];
  logic         wstb_w  [NSIDE];
  logic         rstb_w  [NSIDE];
  logic [W-1:0] lrd_w   [NSIDE];
  logic         loe_n_w [NSIDE];
  logic         lfull_w [NSIDE];
  logic         lovr_w  [NSIDE];
  logic         lrdy_w  [NSIDE];
  logic         ltkn_w  [NSIDE];

  assign sel_w[0] = a_sel;   assign sel_w[1] = b_sel;
  assign we_w[0]  = a_we;    assign we_w[1]  = b_we;
  assign wd_w[0]  = a_wdata; assign wd_w[1]  = b_wdata;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    mbx_port_seq u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel_w[s]),
      .we     (we_w[s]),
      .wr_stb (wstb_w[s]),
      .rd_stb (rstb_w[s])
    );

    mbx_lane #(.W(W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wstb_w[s]),
      .wdata   (wd_w[s]),
      .rd_stb  (rstb_w[NSIDE-1-s]),
      .rdata   (lrd_w[s]),
      .oe_n    (loe_n_w[s]),
      .full    (lfull_w[s]),
      .ovr     (lovr_w[s]),
      .ready_p (lrdy_w[s]),
      .taken_p (ltkn_w[s])
    );
  end

  assign a_rdata = lrd_w[1];
  assign a_oe_n  = loe_n_w[1];
  assign a_ready = lrdy_w[1];
  assign a_taken = ltkn_w[0];
  assign a_full  = lfull_w[0];
  assign a_ovr   = lovr_w[0];

  assign b_rdata = lrd_w[0];
  assign b_oe_n  = loe_n_w[0];
  assign b_ready = lrdy_w[0];
  assign b_taken = ltkn_w[1];
  assign b_full  = lfull_w[1];
  assign b_ovr   = lovr_w[1];

  // R5: a released read bus carries zero
  p_bus_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe_n |-> a_rdata == '0) and (b_oe_n |-> b_rdata == '0));

  // R4: ready toward a side only follows a write strobe from the other side
  p_ready_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    b_ready |-> $past(wstb_w[0]));

endmodule

// File: tb/dual_mailbox_tb_top.sv
module dual_mailbox_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_sel = 0, a_we = 0, b_sel = 0, b_we = 0;
  logic [15:0] a_wdata = '0, b_wdata = '0;
  logic [15:0] a_rdata, b_rdata;
  logic        a_oe_n, a_ready, a_taken, a_full, a_ovr;
  logic        b_oe_n, b_ready, b_taken, b_full, b_ovr;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // snapshots taken in the strobe clock and in the clock after
  logic [15:0] s_ard, s_brd;
  logic        s_aoe, s_boe;

  always #10 clk = ~clk;

  dual_mailbox dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_oe_n(a_oe_n),
    .a_ready(a_ready), .a_taken(a_taken), .a_full(a_full), .a_ovr(a_ovr),
    .b_sel(b_sel), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_oe_n(b_oe_n),
    .b_ready(b_ready), .b_taken(b_taken), .b_full(b_full), .b_ovr(b_ovr)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive both sides for one access; sel of an inactive side stays 0.
  // Returns at the falling edge after the strobe clock, where flag pulses are visible.
  task automatic access2(input bit a_go, input bit awe, input logic [15:0] ad,
                         input bit b_go, input bit bwe, input logic [15:0] bd,
                         input int extra);
    @(negedge clk);
    a_sel = a_go; a_we = awe; a_wdata = ad;
    b_sel = b_go; b_we = bwe; b_wdata = bd;
    @(negedge clk);
    s_ard = a_rdata; s_brd = b_rdata; s_aoe = a_oe_n; s_boe = b_oe_n;
    @(negedge clk);
    if (extra == 0) begin a_sel = 0; b_sel = 0; end
  endtask

  task automatic release_after(input int extra);
    for (int i = 0; i < extra; i++) @(negedge clk);
    a_sel = 0; b_sel = 0;
  endtask

  task automatic t_reset;
    check("R1 a_rdata", a_rdata, 16'h0);
    check("R1 b_rdata", b_rdata, 16'h0);
    check("R1 oe_n pair", {14'h0, a_oe_n, b_oe_n}, 16'h3);
    check("R1 flags", {8'h0, a_ready, a_taken, a_full, a_ovr, b_ready, b_taken, b_full, b_ovr}, 16'h0);
  endtask

  task automatic t_write_then_read;
    access2(1, 1, 16'h1234, 0, 0, 16'h0, 0);
    check("R3 a_full after write", {15'h0, a_full}, 16'h1);
    check("R4 b_ready pulse", {15'h0, b_ready}, 16'h1);
    check("R6 no early taken", {15'h0, a_taken}, 16'h0);
    @(negedge clk);
    check("R4 b_ready one clock", {15'h0, b_ready}, 16'h0);
    check("R5 b_rdata released", b_rdata, 16'h0);
    access2(0, 0, 16'h0, 1, 0, 16'h0, 0);
    check("R5 b_oe_n low in strobe", {15'h0, s_boe}, 16'h0);
    check("R5 b_rdata word", s_brd, 16'h1234);
    check("R5 a_oe_n stays high", {15'h0, s_aoe}, 16'h1);
    check("R6 a_taken pulse", {15'h0, a_taken}, 16'h1);
    check("R6 a_full cleared", {15'h0, a_full}, 16'h0);
    @(negedge clk);
    check("R6 a_taken one clock", {15'h0, a_taken}, 16'h0);
    check("R5 b_oe_n high after", {15'h0, b_oe_n}, 16'h1);
  endtask

  task automatic t_read_empty;
    access2(0, 0, 16'h0, 1, 0, 16'h0, 0);
    check("R8 no taken on empty", {15'h0, a_taken}, 16'h0);
    check("R8 full stays 0", {15'h0, a_full}, 16'h0);
  endtask

  task automatic t_short_and_long;
    @(negedge clk);
    a_sel = 1; a_we = 1; a_wdata = 16'h7777;
    @(negedge clk);
    a_sel = 0;
    check("R2 one-clock select no strobe oe", {15'h0, b_oe_n}, 16'h1);
    @(negedge clk);
    check("R2 one-clock select no capture", {15'h0, a_full}, 16'h0);
    check("R2 one-clock select no ready", {15'h0, b_ready}, 16'h0);
    // select held five clocks: exactly one capture, so no overrun
    access2(1, 1, 16'h4D2E, 0, 0, 16'h0, 3);
    release_after(3);
    @(negedge clk);
    check("R2 long select single capture", {14'h0, a_full, a_ovr}, 16'h2);
    access2(0, 0, 16'h0, 1, 0, 16'h0, 0);
    check("R2 long select word", s_brd, 16'h4D2E);
  endtask

  task automatic t_collision;
    access2(1, 1, 16'hC0DE, 1, 0, 16'h0, 0);
    check("R9 reader sees incoming", s_brd, 16'hC0DE);
    check("R9 no taken", {15'h0, a_taken}, 16'h0);
    check("R9 full stays set", {15'h0, a_full}, 16'h1);
    access2(0, 0, 16'h0, 1, 0, 16'h0, 0);
    check("R9 later read word", s_brd, 16'hC0DE);
    check("R9 later taken", {15'h0, a_taken}, 16'h1);
  endtask

  task automatic t_both_ways;
    access2(1, 1, 16'h1111, 1, 1, 16'h2222, 0);
    check("R10 both full", {14'h0, a_full, b_full}, 16'h3);
    check("R10 both ready", {14'h0, a_ready, b_ready}, 16'h3);
    access2(1, 0, 16'h0, 1, 0, 16'h0, 0);
    check("R10 a reads B word", s_ard, 16'h2222);
    check("R10 b reads A word", s_brd, 16'h1111);
    check("R10 both taken", {14'h0, a_taken, b_taken}, 16'h3);
    check("R10 both empty", {14'h0, a_full, b_full}, 16'h0);
  endtask

  task automatic t_overrun;
    access2(1, 1, 16'hAAAA, 0, 0, 16'h0, 0);
    @(negedge clk);
    access2(1, 1, 16'h5555, 0, 0, 16'h0, 0);
    check("R7 no ready on dropped write", {15'h0, b_ready}, 16'h0);
    check("R7 overrun set", {15'h0, a_ovr}, 16'h1);
    check("R7 other side clean", {15'h0, b_ovr}, 16'h0);
    access2(0, 0, 16'h0, 1, 0, 16'h0, 0);
    check("R7 held word kept", s_brd, 16'hAAAA);
    check("R7 taken after read", {15'h0, a_taken}, 16'h1);
    repeat (3) @(negedge clk);
    check("R7 overrun sticky", {15'h0, a_ovr}, 16'h1);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_then_read();
    t_read_empty();
    t_short_and_long();
    t_collision();
    t_both_ways();
    t_overrun();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

endmodule